// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block collects interrupt events from a peripheral that emulates a 16550-style UART toward a host CPU. It drives a single interrupt request line into an 8-bit processor. Eight event sources feed it. Most of them fire when the host writes one of the emulated UART's configuration registers. The others come from the transmit holding register, the transmitter timeout and the receive buffer. The transmitter timeout fires when characters sit below the FIFO trigger level and the FIFO has been neither read nor written for a programmed interval. Each event pulse sets a sticky pending flag.

A one-byte enable register gates the sources. It has a master enable bit and seven per-source enable bits. A one-byte vector register supplies the byte that is returned on an interrupt acknowledge. The `vectorMode` input selects how that byte is built:
- With `vectorMode` low, the byte is a stored instruction opcode.
- With `vectorMode` high, the byte is the low byte of a table address. Bits 3..1 of that byte carry the code of the highest-priority active source.

An acknowledge captures the byte once. The same acknowledge retires the winning source's pending flag.

The register port uses a 2-bit address:

| Address | Read | Write |
|---|---|---|
| 0 | Enable register | Enable register |
| 1 | Vector register view | Vector register |
| 2 | Pending flags | Write 1 to clear a flag |
| 3 | 0 | Ignored |

Top module: `irq_vector_gen`

## Requirements
- R1: While reset is active, `irq` is 0. After reset, the enable register, the vector register, the pending flags and `ackData` all read 0.
- R2: An `evt[i]` pulse sets pending flag i. The flag stays set until it is cleared by an acknowledge or by a software clear. Pending bit order, from bit 7 down to bit 0, is: transmit holding, transmitter timeout, receive buffer, modem control, line control, divisor low, divisor high, FIFO control or overrun.
- R3: When enable bit 7 (master) is 0, `irq` is 0 and no source counts as active, whatever the other enable bits and flags hold.
- R4: A source is active when its flag is set, its enable bit is 1 and the master bit is 1. `irq` is the OR of all active sources. The enable bits map to sources as follows: bit 6 transmit holding, bit 5 timeout, bit 4 receive, bit 3 line control, bit 2 modem control, bit 1 both divisor sources, bit 0 FIFO control or overrun. Address 0 reads back the enable register.
- R5: Address 2 reads the pending flags. Writing a 1 to a bit clears that flag, and writing a 0 leaves it unchanged. An event arriving in the same cycle as a clear of the same flag keeps the flag set.
- R6: Vector register bits 7..4 always read back the last value written, in either mode.
- R7: With `vectorMode` at 0, address 1 reads all eight stored bits. An acknowledge then returns exactly that stored byte.
- R8: With `vectorMode` at 1, the vector byte reads as {stored bits 7..4, code, 0}. The codes are: transmit holding 6, timeout 5, receive 4, modem control 3, line control 2, divisor low 1, divisor high 1, FIFO control or overrun 0. The code is also 0 when no source is active.
- R9: The code always belongs to the highest-priority active source. Priority runs from the transmit holding source down to the FIFO control or overrun source, in the pending bit order of R2.
- R10: On a cycle with `ackStart` high, `ackData` takes the vector byte as it stood before that clock edge. It then holds until the next acknowledge. An event arriving with the acknowledge does not alter the captured byte.
- R11: An acknowledge clears only the pending flag of the winning active source. If no source is active, it clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 enable, 1 vector, 2 pending, 3 unused (reads 0, writes ignored) |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Combinational read data for `addr` |
| vectorMode | input | 1 | 0: opcode mode, 1: vector mode |
| evt | input | 8 | Source event pulses, in the pending bit order of R2 |
| ackStart | input | 1 | One-cycle pulse at the start of an interrupt acknowledge |
| ackData | output | 8 | Byte captured for the acknowledge |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted pending flag or enable bit shows up on `irq`, and in the vector-mode code read at address 1, on the very next cycle. The block has no pipeline between that state and those outputs. The bench therefore sweeps every 8-bit pending pattern against a set of enable values and compares `irq`, the code and the pending readback with an arithmetic model right after each write. A wrong winner selection on acknowledge shows up one cycle later in two places: in `ackData`, and in the pending flags left behind. The bench checks both after every acknowledge in a drain sequence.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
  localparam int SRC_N  = 8;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 3;
  localparam int ADDR_W = 2;
  localparam int MASTER_BIT = BYTE_W - 1;

  typedef struct packed {
    logic ldEnable;
    logic ldVector;
    logic clrPend;
    logic ackTake;
  } strobe_t;

  typedef enum logic [ADDR_W-1:0] {
    SEL_ENABLE = 2'd0,
    SEL_VECTOR = 2'd1,
    SEL_PEND   = 2'd2,
    SEL_NONE   = 2'd3
  } regsel_t;

  // status code for pending index idx (7 = highest priority)
  function automatic logic [CODE_W-1:0] srcCode(input int idx);
    if (idx >= 2) return CODE_W'(idx - 1);
    return CODE_W'(idx);
  endfunction

  // enable register bit gating pending index idx
  function automatic int enIndex(input int idx);
    case (idx)
      7: return 6;
      6: return 5;
      5: return 4;
      4: return 2;
      3: return 3;
      2: return 1;
      1: return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/ivg_ctrl.sv
module ivg_ctrl
  import ivg_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ackStart,
  output strobe_t           stb
);
  always_comb begin
    stb          = '0;
    stb.ldEnable = wrEn && (addr == SEL_ENABLE);
    stb.ldVector = wrEn && (addr == SEL_VECTOR);
    stb.clrPend  = wrEn && (addr == SEL_PEND);
    stb.ackTake  = ackStart;
  end
endmodule

// File: rtl/ivg_dpath.sv
module ivg_dpath
  import ivg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vectorMode,
  input  logic [SRC_N-1:0]  evt,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] ackData,
  output logic              irq
);
  logic [BYTE_W-1:0] enableReg, vectorReg, vecView;
  logic [SRC_N-1:0]  pend, pendNext, gateMask, active, winner;
  logic [CODE_W-1:0] winCode;
  logic              anyActive;

  generate
    for (genvar g = 0; g < SRC_N; g++) begin : g_gate
      assign gateMask[g] = enableReg[enIndex(g)];
    end
  endgenerate

  assign active    = pend & gateMask & {SRC_N{enableReg[MASTER_BIT]}};
  assign anyActive = |active;
  assign irq       = anyActive;

  // ascending scan: the highest active index overrides lower ones
  always_comb begin
    winner  = '0;
    winCode = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (active[i]) begin
        winner    = '0;
        winner[i] = 1'b1;
        winCode   = srcCode(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < SRC_N; i++) begin
      if (evt[i])
        pendNext[i] = 1'b1;
      else if ((stb.clrPend && wrData[i]) || (stb.ackTake && winner[i]))
        pendNext[i] = 1'b0;
      else
        pendNext[i] = pend[i];
    end
  end

  assign vecView = vectorMode ? {vectorReg[BYTE_W-1:CODE_W+1], winCode, 1'b0}
                              : vectorReg;

  always_comb begin
    case (addr)
      SEL_ENABLE: rdData = enableReg;
      SEL_VECTOR: rdData = vecView;
      SEL_PEND:   rdData = BYTE_W'(pend);
      default:    rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= '0;
      vectorReg <= '0;
      pend      <= '0;
      ackData   <= '0;
    end else begin
      if (stb.ldEnable) enableReg <= wrData;
      if (stb.ldVector) vectorReg <= wrData;
      pend <= pendNext;
      if (stb.ackTake) ackData <= vecView;
    end
  end

  generate
    for (genvar g = 0; g < SRC_N; g++) begin : g_chk
      // R2
      evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
        evt[g] |=> pend[g]);
    end
  endgenerate

  // R3
  master_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldEnable && !wrData[MASTER_BIT]) |=> !irq);

  // R10
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ackTake |=> $stable(ackData));

  // R8
  ack_bit0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackTake && vectorMode) |=> (ackData[0] == 1'b0));

  // R11
  ack_retire_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackTake && anyActive && (evt == '0) && !stb.clrPend)
      |=> ($countones(pend) == $past($countones(pend)) - 1));
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import ivg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              vectorMode,
  input  logic [SRC_N-1:0]  evt,
  input  logic              ackStart,
  output logic [BYTE_W-1:0] ackData,
  output logic              irq
);
  strobe_t stb;

  ivg_ctrl u_ctrl (
    .wrEn     (wrEn),
    .addr     (addr),
    .ackStart (ackStart),
    .stb      (stb)
  );

  ivg_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .addr       (addr),
    .vectorMode (vectorMode),
    .evt        (evt),
    .rdData     (rdData),
    .ackData    (ackData),
    .irq        (irq)
  );
endmodule

// File: tb/irq_vector_gen_tb.sv
module irq_vector_gen_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       vectorMode = 1'b0;
  logic [7:0] evt = 8'd0;
  logic       ackStart = 1'b0;
  logic [7:0] ackData;
  logic       irq;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vector_gen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .vectorMode(vectorMode), .evt(evt),
    .ackStart(ackStart), .ackData(ackData), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic pulseEvt(input logic [7:0] p);
    @(negedge clk); evt = p;
    @(negedge clk); evt = 8'd0;
    #1;
  endtask

  task automatic doAck(input logic [7:0] withEvt);
    @(negedge clk); ackStart = 1'b1; evt = withEvt;
    @(negedge clk); ackStart = 1'b0; evt = 8'd0;
    #1;
  endtask

  // model: enable bit for pending index i
  function automatic logic enOf(input int i, input logic [7:0] e);
    case (i)
      7: return e[6];
      6: return e[5];
      5: return e[4];
      4: return e[2];
      3: return e[3];
      2: return e[1];
      1: return e[1];
      default: return e[0];
    endcase
  endfunction

  function automatic logic [7:0] actOf(input logic [7:0] p, input logic [7:0] e);
    logic [7:0] a;
    for (int i = 0; i < 8; i++) a[i] = p[i] & enOf(i, e) & e[7];
    return a;
  endfunction

  function automatic logic [2:0] codeOf(input logic [7:0] a);
    logic [2:0] c = 3'd0;
    for (int i = 0; i < 8; i++) if (a[i]) c = (i >= 2) ? 3'(i - 1) : 3'(i);
    return c;
  endfunction

  function automatic logic [7:0] winOf(input logic [7:0] a);
    logic [7:0] w = 8'd0;
    for (int i = 0; i < 8; i++) if (a[i]) begin w = 8'd0; w[i] = 1'b1; end
    return w;
  endfunction

  function automatic logic [7:0] enSel(input int k);
    case (k)
      0: return 8'hFF;
      1: return 8'h7F;
      2: return 8'h80;
      3: return 8'hC4;
      4: return 8'h9A;
      default: return 8'hA3;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, pm, a, e;
    #3;
    chk("R1 irq in reset", {7'd0, irq}, 8'd0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    rd(2'd0, d); chk("R1 enable reset", d, 8'd0);
    rd(2'd1, d); chk("R1 vector reset", d, 8'd0);
    rd(2'd2, d); chk("R1 pending reset", d, 8'd0);
    chk("R1 ackData reset", ackData, 8'd0);
    chk("R1 irq after reset", {7'd0, irq}, 8'd0);

    // exhaustive pending sweep against enable set
    wr(2'd1, 8'hB7);
    for (int p = 0; p < 256; p++) begin
      vectorMode = 1'b1;
      wr(2'd2, 8'hFF);
      pulseEvt(8'(p));
      rd(2'd2, d); chk("R2 R5 pending readback", d, 8'(p));
      for (int k = 0; k < 6; k++) begin
        e = enSel(k);
        wr(2'd0, e);
        a = actOf(8'(p), e);
        rd(2'd0, d); chk("R4 enable readback", d, e);
        chk(e[7] ? "R4 irq" : "R3 irq masked", {7'd0, irq}, {7'd0, |a});
        rd(2'd1, d); chk("R8 R9 code view", d, {4'hB, codeOf(a), 1'b0});
      end
      vectorMode = 1'b0;
      rd(2'd1, d); chk("R7 opcode view", d, 8'hB7);
    end

    // partial software clear
    wr(2'd2, 8'hFF); pulseEvt(8'h5B); wr(2'd2, 8'h0F);
    rd(2'd2, d); chk("R5 w1c partial", d, 8'h50);
    // clear and event collide
    @(negedge clk); wrEn = 1'b1; addr = 2'd2; wrData = 8'h50; evt = 8'h40;
    @(negedge clk); wrEn = 1'b0; evt = 8'd0; #1;
    rd(2'd2, d); chk("R5 event beats clear", d, 8'h40);

    // drain with acknowledges in vector mode
    wr(2'd2, 8'hFF); wr(2'd0, 8'hFF); wr(2'd1, 8'hA5); vectorMode = 1'b1;
    pulseEvt(8'hDB);
    pm = 8'hDB;
    for (int n = 0; n < 8; n++) begin
      a = actOf(pm, 8'hFF);
      doAck(8'd0);
      chk("R10 ack byte", ackData, {4'hA, codeOf(a), 1'b0});
      pm = pm & ~winOf(a);
      rd(2'd2, d); chk("R11 ack retires winner", d, pm);
    end
    doAck(8'd0);
    chk("R8 ack none active", ackData, 8'hA0);
    rd(2'd1, d); chk("R6 upper nibble", d[7:4], 8'h0A);

    // higher-priority event during acknowledge
    pulseEvt(8'h01);
    doAck(8'h80);
    chk("R10 ack byte frozen", ackData, 8'hA0);
    rd(2'd2, d); chk("R10 R11 late event kept", d, 8'h80);
    pulseEvt(8'h20);
    chk("R10 ack holds", ackData, 8'hA0);

    // opcode mode acknowledge
    vectorMode = 1'b0;
    doAck(8'd0);
    chk("R7 opcode ack", ackData, 8'hA5);
    rd(2'd2, d); chk("R11 opcode ack clears", d, 8'h20);

    // master off: ack clears nothing
    wr(2'd0, 8'h7F);
    vectorMode = 1'b1;
    doAck(8'd0);
    chk("R3 ack masked byte", ackData, 8'hA0);
    rd(2'd2, d); chk("R11 nothing cleared", d, 8'h20);
    chk("R3 irq masked", {7'd0, irq}, 8'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule